// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns reset requests from several internal sources into one chip-wide reset. Power-up and brown-out events trigger a long clock-settling count followed by a short release phase. Watchdog expiry, an illegal instruction fetch, an out-of-range access and a monitor-mode request trigger only the release phase. All counting is done in cycles of the oscillator clock. The block drives an open-drain reset pad low for the first half of the release phase. It gates the CPU and peripheral clocks off while the oscillator settles, and it emits a single pulse when the CPU may begin fetching its reset vector.

The block keeps a record of every cause in a sticky six-bit register. Software reads this register, and the read strobe clears it. A power-up event wipes the register and sets only the power bit. Any other cause adds its own bit and keeps the bits already set. A new request during a running sequence restarts the sequence at the phase its type requires.

Top module: `reset_sequencer`

## Requirements
- R1: While `porIn` is high, `intRst` is 1, `clkGateEn` is 0, `vecFetchStart` is 0 and `causeStatus` is 6'b000001 (bit 0 = power-up). After `porIn` falls, `vecFetchStart` pulses on the 4163rd rising clock edge, and `intRst` has been high for 4160 cycles.
- R2: A `lviReq` sampled high at a clock edge sets status bit 1 and restarts the full sequence. The sequence is 4096 settling cycles, then 64 release cycles, then 3 fetch-lead cycles, and `vecFetchStart` comes 4163 edges after the request edge.
- R3: An `illOpReq` (status bit 3), `illAddrReq` (bit 4) or `monReq` (bit 5) arriving while no sequence runs starts a release-only sequence. `intRst` is high for 64 cycles and `vecFetchStart` pulses 67 edges after the request edge.
- R4: `rstPinDriveN` is 0 for exactly the first 32 cycles of the release phase and is never 0 while `intRst` is 0.
- R5: `clkGateEn` is 0 exactly during the settling count (4096 cycles) and 1 at all other times outside `porIn`.
- R6: A `copReqAsync` pulse of any width, even shorter than a clock period, is captured. It sets status bit 2 and starts a release-only sequence on the third rising edge after the pulse, so `vecFetchStart` comes 70 edges after it.
- R7: A cause bit, once set, stays set until a `statusRd` strobe. A `statusRd` at an edge clears all bits, except a cause arriving at that same edge, which is recorded.
- R8: A non-power request during the release or fetch-lead phase restarts the release phase from its first cycle. During the settling count it only records its bit, and the sequence continues unchanged.
- R9: A `lviReq` arriving during any phase restarts the 4096-cycle settling count. If it arrives together with other requests, the long path is taken and every requested bit is set.
- R10: `vecFetchStart` is high for exactly one cycle, only at the completion of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| porIn | input | 1 | Power-up event, asynchronous, active high |
| lviReq | input | 1 | Low-voltage event, synchronous |
| copReqAsync | input | 1 | Watchdog expiry, asynchronous, any width |
| illOpReq | input | 1 | Illegal opcode request, synchronous |
| illAddrReq | input | 1 | Illegal address request, synchronous |
| monReq | input | 1 | Monitor-mode reset request, synchronous |
| statusRd | input | 1 | Software read strobe for the cause register |
| intRst | output | 1 | Internal reset, active high |
| rstPinDriveN | output | 1 | Open-drain pad drive enable, active low |
| clkGateEn | output | 1 | CPU and peripheral clock enable |
| vecFetchStart | output | 1 | One-cycle pulse: start of reset vector fetch |
| causeStatus | output | 6 | Cause register: bit0 power, 1 voltage, 2 watchdog, 3 opcode, 4 address, 5 monitor |

## Verification
A wrong phase or counter value inside the block shows up at the ports as a shifted edge. The fall of `rstPinDriveN`, the rise of `clkGateEn`, the fall of `intRst` or the `vecFetchStart` pulse appears at the wrong edge count, so every sequence is timed edge by edge from its trigger. A lost restart or a missed watchdog pulse shows as a sequence length of 67 or 4163 counted from the wrong origin, and this is visible within one sequence. Errors in the cause register appear at the `causeStatus` port on the cycle after the triggering edge, and the bench reads it back after each sequence.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_STAB = 2'd1,
    SEQ_REL  = 2'd2,
    SEQ_LEAD = 2'd3
  } seqState_t;

  // Strobes from the control FSM to the datapath counter
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } seqStrobe_t;

  localparam int CAUSE_W       = 6;
  localparam int CAUSE_POR     = 0;
  localparam int CAUSE_LVI     = 1;
  localparam int CAUSE_COP     = 2;
  localparam int CAUSE_ILLOP   = 3;
  localparam int CAUSE_ILLADDR = 4;
  localparam int CAUSE_MON     = 5;

  function automatic int maxOf3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rst_seq_datapath.sv
module rst_seq_datapath
  import rst_seq_pkg::*;
#(
  parameter int STAB_CYCLES    = 4096,
  parameter int RELEASE_CYCLES = 64,
  parameter int PIN_CYCLES     = 32,
  parameter int LEAD_CYCLES    = 3,
  parameter int SYNC_STAGES    = 2
) (
  input  logic               clk,
  input  logic               porIn,
  input  logic               copReqAsync,
  input  logic               lviReq,
  input  logic               illOpReq,
  input  logic               illAddrReq,
  input  logic               monReq,
  input  logic               statusRd,
  input  seqStrobe_t         strobe,
  output logic               pwrEvt,
  output logic               otherEvt,
  output logic               stabDone,
  output logic               relDone,
  output logic               leadDone,
  output logic               pinWin,
  output logic [CAUSE_W-1:0] causeStatus
);

  localparam int MAX_CNT = maxOf3(STAB_CYCLES, RELEASE_CYCLES, LEAD_CYCLES);
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [CNT_W-1:0]       cnt;
  logic                   copPend;
  logic [SYNC_STAGES-1:0] copSync;
  logic                   copSeen;
  logic                   copEvt;
  logic [CAUSE_W-1:0]     setVec;

  // Watchdog request: asynchronously latched, then synchronized
  always_ff @(posedge clk or posedge porIn or posedge copReqAsync) begin
    if (porIn)
      copPend <= 1'b0;
    else if (copReqAsync)
      copPend <= 1'b1;
    else if (copSync[SYNC_STAGES-1])
      copPend <= 1'b0;
  end

  generate
    genvar gi;
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      always_ff @(posedge clk or posedge porIn) begin
        if (porIn)
          copSync[gi] <= 1'b0;
        else if (gi == 0)
          copSync[gi] <= copPend;
        else
          copSync[gi] <= copSync[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)
      copSeen <= 1'b0;
    else
      copSeen <= copSync[SYNC_STAGES-1];
  end

  assign copEvt = copSync[SYNC_STAGES-1] & ~copSeen;

  // Cause vector for this cycle
  always_comb begin
    setVec                = '0;
    setVec[CAUSE_LVI]     = lviReq;
    setVec[CAUSE_COP]     = copEvt;
    setVec[CAUSE_ILLOP]   = illOpReq;
    setVec[CAUSE_ILLADDR] = illAddrReq;
    setVec[CAUSE_MON]     = monReq;
  end

  assign pwrEvt   = lviReq;
  assign otherEvt = copEvt | illOpReq | illAddrReq | monReq;

  // Sticky cause register, read-to-clear
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)
      causeStatus <= CAUSE_W'(1) << CAUSE_POR;
    else
      causeStatus <= (statusRd ? '0 : causeStatus) | setVec;
  end

  // Phase counter
  always_ff @(posedge clk or posedge porIn) begin
    if (porIn)
      cnt <= '0;
    else if (strobe.cntClr)
      cnt <= '0;
    else if (strobe.cntInc)
      cnt <= cnt + 1'b1;
  end

  assign stabDone = (cnt == CNT_W'(STAB_CYCLES - 1));
  assign relDone  = (cnt == CNT_W'(RELEASE_CYCLES - 1));
  assign leadDone = (cnt == CNT_W'(LEAD_CYCLES - 1));
  assign pinWin   = (cnt < CNT_W'(PIN_CYCLES));

  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (porIn)
    !statusRd |=> ((causeStatus & $past(causeStatus)) == $past(causeStatus)));

  // R6
  cop_single_evt_chk: assert property (@(posedge clk) disable iff (porIn)
    copEvt |=> !copEvt);

  // R2
  lvi_bit_chk: assert property (@(posedge clk) disable iff (porIn)
    lviReq |=> causeStatus[CAUSE_LVI]);

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic       clk,
  input  logic       porIn,
  input  logic       pwrEvt,
  input  logic       otherEvt,
  input  logic       stabDone,
  input  logic       relDone,
  input  logic       leadDone,
  input  logic       pinWin,
  output seqStrobe_t strobe,
  output logic       intRst,
  output logic       rstPinDriveN,
  output logic       clkGateEn,
  output logic       vecFetchStart
);

  seqState_t state, nState;
  logic      seqDone;

  always_comb begin
    nState        = state;
    strobe.cntClr = 1'b0;
    strobe.cntInc = 1'b0;
    seqDone       = 1'b0;
    if (pwrEvt) begin
      nState        = SEQ_STAB;
      strobe.cntClr = 1'b1;
    end else if (otherEvt && state != SEQ_STAB) begin
      nState        = SEQ_REL;
      strobe.cntClr = 1'b1;
    end else begin
      unique case (state)
        SEQ_IDLE: ;
        SEQ_STAB: begin
          if (stabDone) begin
            nState        = SEQ_REL;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        SEQ_REL: begin
          if (relDone) begin
            nState        = SEQ_LEAD;
            strobe.cntClr = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        SEQ_LEAD: begin
          if (leadDone) begin
            nState        = SEQ_IDLE;
            strobe.cntClr = 1'b1;
            seqDone       = 1'b1;
          end else begin
            strobe.cntInc = 1'b1;
          end
        end
        default: nState = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or posedge porIn) begin
    if (porIn) begin
      state         <= SEQ_STAB;
      vecFetchStart <= 1'b0;
    end else begin
      state         <= nState;
      vecFetchStart <= seqDone;
    end
  end

  assign intRst       = (state == SEQ_STAB) || (state == SEQ_REL);
  assign clkGateEn    = (state != SEQ_STAB);
  assign rstPinDriveN = !((state == SEQ_REL) && pinWin);

  // R4
  pin_in_reset_chk: assert property (@(posedge clk) disable iff (porIn)
    !rstPinDriveN |-> intRst);

  // R5
  gate_in_reset_chk: assert property (@(posedge clk) disable iff (porIn)
    !clkGateEn |-> intRst);

  // R10
  vec_one_cycle_chk: assert property (@(posedge clk) disable iff (porIn)
    vecFetchStart |=> !vecFetchStart);

  // R10
  vec_not_in_reset_chk: assert property (@(posedge clk) disable iff (porIn)
    vecFetchStart |-> !intRst);

  // R9
  lvi_restart_chk: assert property (@(posedge clk) disable iff (porIn)
    pwrEvt |=> (!clkGateEn && intRst && rstPinDriveN));

  // R3
  release_start_chk: assert property (@(posedge clk) disable iff (porIn)
    (otherEvt && !pwrEvt && clkGateEn) |=> (!rstPinDriveN && intRst));

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rst_seq_pkg::*;
#(
  parameter int STAB_CYCLES    = 4096,
  parameter int RELEASE_CYCLES = 64,
  parameter int PIN_CYCLES     = 32,
  parameter int LEAD_CYCLES    = 3
) (
  input  logic               clk,
  input  logic               porIn,
  input  logic               lviReq,
  input  logic               copReqAsync,
  input  logic               illOpReq,
  input  logic               illAddrReq,
  input  logic               monReq,
  input  logic               statusRd,
  output logic               intRst,
  output logic               rstPinDriveN,
  output logic               clkGateEn,
  output logic               vecFetchStart,
  output logic [CAUSE_W-1:0] causeStatus
);

  seqStrobe_t strobe;
  logic pwrEvt, otherEvt, stabDone, relDone, leadDone, pinWin;

  rst_seq_datapath #(
    .STAB_CYCLES   (STAB_CYCLES),
    .RELEASE_CYCLES(RELEASE_CYCLES),
    .PIN_CYCLES    (PIN_CYCLES),
    .LEAD_CYCLES   (LEAD_CYCLES),
    .SYNC_STAGES   (2)
  ) dp_i (
    .clk        (clk),
    .porIn      (porIn),
    .copReqAsync(copReqAsync),
    .lviReq     (lviReq),
    .illOpReq   (illOpReq),
    .illAddrReq (illAddrReq),
    .monReq     (monReq),
    .statusRd   (statusRd),
    .strobe     (strobe),
    .pwrEvt     (pwrEvt),
    .otherEvt   (otherEvt),
    .stabDone   (stabDone),
    .relDone    (relDone),
    .leadDone   (leadDone),
    .pinWin     (pinWin),
    .causeStatus(causeStatus)
  );

  rst_seq_ctrl ctrl_i (
    .clk          (clk),
    .porIn        (porIn),
    .pwrEvt       (pwrEvt),
    .otherEvt     (otherEvt),
    .stabDone     (stabDone),
    .relDone      (relDone),
    .leadDone     (leadDone),
    .pinWin       (pinWin),
    .strobe       (strobe),
    .intRst       (intRst),
    .rstPinDriveN (rstPinDriveN),
    .clkGateEn    (clkGateEn),
    .vecFetchStart(vecFetchStart)
  );

endmodule

// File: tb/reset_sequencer_tb.sv
module reset_sequencer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LONG_LEN   = 4163;
  localparam int SHORT_LEN  = 67;
  localparam int NVEC       = 6;

  // {reqMask[37:32], expLen[31:19], expStat[18:13], expRst[12:0]}
  // reqMask bits: 1 voltage, 3 opcode, 4 address, 5 monitor
  localparam logic [37:0] VEC [NVEC] = '{
    {6'b001000, 13'd67,   6'b001000, 13'd64},
    {6'b010000, 13'd67,   6'b010000, 13'd64},
    {6'b100000, 13'd67,   6'b100000, 13'd64},
    {6'b000010, 13'd4163, 6'b000010, 13'd4160},
    {6'b001010, 13'd4163, 6'b001010, 13'd4160},
    {6'b110000, 13'd67,   6'b110000, 13'd64}
  };

  logic clk = 1'b0;
  logic porIn, lviReq, copReqAsync, illOpReq, illAddrReq, monReq, statusRd;
  logic intRst, rstPinDriveN, clkGateEn, vecFetchStart;
  logic [5:0] causeStatus;

  int nTests = 0;
  int nFail  = 0;
  int mLen, mRst, mGateLow, mPinLow, mPinBad, mVecAfter;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_sequencer dut_i (
    .clk(clk), .porIn(porIn), .lviReq(lviReq), .copReqAsync(copReqAsync),
    .illOpReq(illOpReq), .illAddrReq(illAddrReq), .monReq(monReq),
    .statusRd(statusRd), .intRst(intRst), .rstPinDriveN(rstPinDriveN),
    .clkGateEn(clkGateEn), .vecFetchStart(vecFetchStart),
    .causeStatus(causeStatus)
  );

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Samples now, then after every edge until vecFetchStart is seen
  task automatic measure();
    mLen = 0; mRst = 0; mGateLow = 0; mPinLow = 0; mPinBad = 0; mVecAfter = 0;
    while (!vecFetchStart && mLen < 5000) begin
      if (intRst) mRst++;
      if (!clkGateEn) mGateLow++;
      if (!rstPinDriveN) mPinLow++;
      if (!rstPinDriveN && !intRst) mPinBad++;
      @(posedge clk); @(negedge clk);
      mLen++;
    end
    @(posedge clk); @(negedge clk);
    mVecAfter = vecFetchStart;
  endtask

  // Drive request mask at a negedge, hold over one edge, release
  task automatic applyReq(input logic [5:0] mask, input logic rd);
    lviReq     = mask[1];
    illOpReq   = mask[3];
    illAddrReq = mask[4];
    monReq     = mask[5];
    statusRd   = rd;
    @(posedge clk); @(negedge clk);
    lviReq = 0; illOpReq = 0; illAddrReq = 0; monReq = 0; statusRd = 0;
  endtask

  task automatic clearStatus();
    applyReq(6'b0, 1'b1);
  endtask

  task automatic waitEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    porIn = 1; lviReq = 0; copReqAsync = 0; illOpReq = 0; illAddrReq = 0;
    monReq = 0; statusRd = 0;
    waitEdges(3);
    // R1 reset state
    check("R1 intRst in por", intRst, 1);
    check("R1 clkGateEn in por", clkGateEn, 0);
    check("R1 vecFetchStart in por", vecFetchStart, 0);
    check("R1 status in por", causeStatus, 6'b000001);
    porIn = 0;
    measure();
    check("R1 por length", mLen, LONG_LEN);
    check("R1 por intRst cycles", mRst, 4160);
    check("R5 por gate-off cycles", mGateLow, 4096);
    check("R4 por pin cycles", mPinLow, 32);
    check("R4 pin outside reset", mPinBad, 0);
    check("R10 por pulse width", mVecAfter, 0);
    check("R1 status after por", causeStatus, 6'b000001);
    clearStatus();
    check("R7 read clears", causeStatus, 0);

    // Table walk: R2 R3 R9
    for (int v = 0; v < NVEC; v++) begin
      clearStatus();
      applyReq(VEC[v][37:32], 1'b0);
      measure();
      check("R3/R2 vec length", mLen, int'(VEC[v][31:19]));
      check("R3/R2 vec intRst cycles", mRst, int'(VEC[v][12:0]));
      check("R5 vec gate-off cycles", mGateLow,
            (VEC[v][31:19] == 13'd4163) ? 4096 : 0);
      check("R4 vec pin cycles", mPinLow, 32);
      check("R4 vec pin outside reset", mPinBad, 0);
      check("R10 vec pulse width", mVecAfter, 0);
      check("R9 vec status", causeStatus, int'(VEC[v][18:13]));
    end

    // R6 sub-cycle watchdog pulse
    clearStatus();
    #2 copReqAsync = 1;
    #1 copReqAsync = 0;
    measure();
    check("R6 cop length from pulse", mLen, 70);
    check("R6 cop intRst cycles", mRst, 64);
    check("R6 cop status", causeStatus, 6'b000100);

    // R7 sticky accumulation without read
    clearStatus();
    applyReq(6'b001000, 1'b0);
    measure();
    applyReq(6'b100000, 1'b0);
    measure();
    check("R7 sticky bits", causeStatus, 6'b101000);

    // R7 read at same edge as a new cause
    applyReq(6'b010000, 1'b1);
    check("R7 read with new cause", causeStatus, 6'b010000);
    measure();
    check("R7 length after read", mLen, SHORT_LEN);

    // R8 restart during release
    clearStatus();
    applyReq(6'b001000, 1'b0);
    waitEdges(40);
    applyReq(6'b100000, 1'b0);
    measure();
    check("R8 restart length", mLen, SHORT_LEN);
    check("R8 restart intRst cycles", mRst, 64);
    check("R8 restart pin cycles", mPinLow, 32);

    // R8 restart during fetch lead (intRst already low)
    applyReq(6'b001000, 1'b0);
    waitEdges(65);
    check("R8 in lead intRst", intRst, 0);
    applyReq(6'b010000, 1'b0);
    measure();
    check("R8 lead restart length", mLen, SHORT_LEN);

    // R8 non-power request during settling does not shorten it
    clearStatus();
    applyReq(6'b000010, 1'b0);
    waitEdges(100);
    applyReq(6'b001000, 1'b0);
    measure();
    check("R8 stab not shortened", mLen, LONG_LEN - 101);
    check("R8 stab status", causeStatus, 6'b001010);

    // R9 voltage event during release restarts the long count
    clearStatus();
    applyReq(6'b001000, 1'b0);
    waitEdges(10);
    applyReq(6'b000010, 1'b0);
    measure();
    check("R9 lvi restart length", mLen, LONG_LEN);
    check("R9 lvi restart gate-off", mGateLow, 4096);

    // R10 no pulse while idle
    waitEdges(20);
    check("R10 idle no pulse", vecFetchStart, 0);
    check("R10 idle intRst", intRst, 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule